// File: doc/BRIEF.md
# Packed-Decimal / Binary Integer Converter

This block moves a signed integer between two encodings. One is a ten-byte packed-decimal operand. Nine of its bytes each carry two decimal digits, with the upper nibble as the more significant digit. The tenth byte carries the sign in its top bit. The other encoding is a two's-complement binary word. The block does one byte per clock through a simple byte port: a byte address, a read strobe with a byte returned in the same cycle, or a write strobe with a byte to store.

A one-cycle `start` launches a conversion, and `store_mode` picks the direction.

- **Load direction.** The block reads the digit-pair bytes from the most significant downward, accumulating as it goes, and reads the sign byte last. On the pulse of `done`, the binary result appears on `bin_out`.
- **Store direction.** The block takes the magnitude and sign of `bin_in`. It writes the sign byte first, then writes the digit pairs from address 0 upward. Once the magnitude is exhausted the remaining pairs come out as zero.

A load flags any nibble above nine. A store flags any magnitude that needs more than the available digits. Neither flag stops the conversion.

Top module: `bcd_bin_xcvr`

## Requirements
- R1: After reset `busy`, `done`, `byte_rd`, `byte_wr`, `bad_digit` and `overflow` are 0, `st_byte` is 0x00 and `bin_out` is 0.
- R2: A `start` seen while idle gives exactly 10 cycles with `busy`=1, followed by one cycle with `done`=1 and `busy`=0, after which `done` returns to 0. A `start` raised while busy has no effect on that sequence.
- R3: In load mode (`store_mode`=0) `byte_rd` is 1 and `byte_wr` is 0 in every busy cycle. The addresses read are 8, 7, …, 0 and then 9.
- R4: A load produces acc = acc*100 + hi*10 + lo over bytes 8 down to 0, starting from zero, where hi is bits 7:4 and lo is bits 3:0. `bin_out` shows the result in the `done` cycle.
- R5: A load negates the result (two's complement) when bit 7 of byte 9 is 1. The other bits of byte 9 have no effect.
- R6: A load in which any nibble of bytes 0..8 exceeds 9 sets `bad_digit` in the `done` cycle. The conversion still runs to completion, using the raw nibble values in the R4 formula.
- R7: In store mode the first busy cycle has `byte_wr`=1 and address 9. `st_byte` is 0x80 in that cycle when `bin_in` is negative and 0x00 otherwise.
- R8: The next nine store cycles write addresses 0, 1, …, 8 in order. Each byte is (tens << 4) | units of the current magnitude mod 100, and the magnitude is then divided by 100.
- R9: Store bytes above the most significant nonzero digit pair are 0x00.
- R10: A store of magnitude ≥ 10^18, including -2^63 with magnitude 2^63, sets `overflow` in the `done` cycle. The low 18 digits are still written.
- R11: `bin_out` changes only in the cycle of a load's `done`. Both flags are cleared by an accepted `start` and otherwise hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a conversion; accepted only when idle |
| store_mode | input | 1 | 0 = packed decimal to binary, 1 = binary to packed decimal |
| bin_in | input | 64 | Signed value to store, sampled on the accepted start |
| ld_byte | input | 8 | Byte read at `byte_addr` in the same cycle |
| byte_addr | output | 4 | Byte address of the current transfer |
| byte_rd | output | 1 | Read strobe (load mode) |
| byte_wr | output | 1 | Write strobe (store mode) |
| st_byte | output | 8 | Byte to write when `byte_wr` is 1 |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| bin_out | output | 64 | Signed result of the last load |
| bad_digit | output | 1 | A nibble above 9 was seen in the last conversion |
| overflow | output | 1 | The last store magnitude did not fit in 18 digits |

## Verification
The bench builds the block with its default parameters: nine digit pairs and a 64-bit binary word. This size brings within reach the real boundary cases: the eighteen-nines maximum in both signs, the 10^18 overflow threshold, and the most negative word, whose magnitude does not fit as a positive value of the same width. A behavioural model computes the expected address, strobe and byte for every busy cycle, along with the final value and flags. These are compared while `start` is also raised in the middle of a conversion to show that it is ignored.

// File: rtl/bcd_xcvr_pkg.sv
package bcd_xcvr_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_DONE = 2'd2
   } phase_t;

   // 10**n in a wide word, for limits derived from the digit count
   function automatic logic [127:0] pow10(input int n);
      logic [127:0] r;
      r = 128'd1;
      for (int i = 0; i < n; i++) r = r * 128'd10;
      return r;
   endfunction

endpackage

// File: rtl/bcd_step_seq.sv
module bcd_step_seq #(
   parameter int NBYTE = 10,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          store_mode,
   output logic          launch,
   output logic          busy,
   output logic          done,
   output logic          last,
   output logic          first,
   output logic          is_store,
   output logic          rd,
   output logic          wr,
   output logic [AW-1:0] addr
);
   import bcd_xcvr_pkg::*;

   localparam logic [AW-1:0] TOP_A  = AW'(NBYTE - 1);
   localparam logic [AW-1:0] HIGH_A = AW'(NBYTE - 2);

   phase_t        phase;
   logic [AW-1:0] step;
   logic          mode_q;

   assign launch   = (phase == PH_IDLE) && start;
   assign busy     = (phase == PH_RUN);
   assign done     = (phase == PH_DONE);
   assign last     = busy && (step == TOP_A);
   assign first    = busy && (step == '0);
   assign is_store = mode_q;
   assign rd       = busy && !mode_q;
   assign wr       = busy && mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         step   <= '0;
         mode_q <= 1'b0;
      end else begin
         case (phase)
            PH_IDLE: if (start) begin
               phase  <= PH_RUN;
               step   <= '0;
               mode_q <= store_mode;
            end
            PH_RUN: if (step == TOP_A) phase <= PH_DONE;
                    else step <= step + AW'(1);
            default: phase <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      if (!busy)       addr = '0;
      else if (mode_q) addr = (step == '0) ? TOP_A : step - AW'(1);
      else             addr = (step == TOP_A) ? TOP_A : HIGH_A - step;
   end

   a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r2_done_follows_run: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(busy));
   a_r2_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> busy);
   a_r3_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd, wr}));
   a_r3_rd_descend: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr != '0 && addr != TOP_A) |=> (rd && addr == $past(addr) - AW'(1)));
   a_r3_rd_sign_last: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && addr == '0) |=> (rd && addr == TOP_A));
   a_r7_sign_then_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == TOP_A) |=> (wr && addr == '0));
   a_r8_wr_ascend: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr < HIGH_A) |=> (wr && addr == $past(addr) + AW'(1)));

endmodule

// File: rtl/bcd_load_acc.sv
module bcd_load_acc #(
   parameter int BW = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en_pair,
   input  logic          en_sign,
   input  logic [7:0]    byte_in,
   output logic [BW-1:0] result,
   output logic          bad
);
   logic [BW-1:0] acc;
   logic [1:0]    nib_bad;

   for (genvar n = 0; n < 2; n++) begin : g_nib
      assign nib_bad[n] = (byte_in[4*n+3 -: 4] > 4'd9);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc    <= '0;
         result <= '0;
         bad    <= 1'b0;
      end else begin
         if (clr) begin
            acc <= '0;
            bad <= 1'b0;
         end else if (en_pair) begin
            acc <= acc * BW'(100) + BW'(byte_in[7:4]) * BW'(10) + BW'(byte_in[3:0]);
            if (|nib_bad) bad <= 1'b1;
         end
         if (en_sign) result <= byte_in[7] ? (~acc + BW'(1)) : acc;
      end
   end

   a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (bad && !clr) |=> bad);
   a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en_sign |=> $stable(result));

endmodule

// File: rtl/bcd_store_gen.sv
module bcd_store_gen #(
   parameter int BW    = 64,
   parameter int NPAIR = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic          is_store,
   input  logic [BW-1:0] value,
   input  logic          shift,
   output logic [7:0]    sign_byte,
   output logic [7:0]    pair_byte,
   output logic          ovf
);
   localparam logic [BW-1:0] LIMIT = BW'(bcd_xcvr_pkg::pow10(2 * NPAIR));

   logic [BW-1:0] mag;
   logic [BW-1:0] abs_in;
   logic          neg;
   logic [6:0]    rem;

   assign abs_in    = value[BW-1] ? (~value + BW'(1)) : value;
   assign rem       = 7'(mag % BW'(100));
   assign pair_byte = {4'(rem / 7'd10), 4'(rem % 7'd10)};
   assign sign_byte = neg ? 8'h80 : 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mag <= '0;
         neg <= 1'b0;
         ovf <= 1'b0;
      end else if (launch) begin
         mag <= abs_in;
         neg <= value[BW-1];
         ovf <= is_store && (abs_in >= LIMIT);
      end else if (shift) begin
         mag <= mag / BW'(100);
      end
   end

   a_r9_zero_pad: assert property (@(posedge clk) disable iff (!rst_n)
      (shift && mag == '0) |-> (pair_byte == 8'h00));
   a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !launch |=> $stable(ovf));

endmodule

// File: rtl/bcd_bin_xcvr.sv
module bcd_bin_xcvr #(
   parameter int NPAIR = 9,
   parameter int BW    = 64,
   localparam int NBYTE = NPAIR + 1,
   localparam int AW    = $clog2(NBYTE)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          store_mode,
   input  logic [BW-1:0] bin_in,
   input  logic [7:0]    ld_byte,
   output logic [AW-1:0] byte_addr,
   output logic          byte_rd,
   output logic          byte_wr,
   output logic [7:0]    st_byte,
   output logic          busy,
   output logic          done,
   output logic [BW-1:0] bin_out,
   output logic          bad_digit,
   output logic          overflow
);
   if (NPAIR < 1 || BW < 8 || BW > 64) begin : g_bad_size
      $error("bcd_bin_xcvr: NPAIR or BW out of range");
   end
   if (bcd_xcvr_pkg::pow10(2 * NPAIR) > (128'd1 << (BW - 1))) begin : g_bad_fit
      $error("bcd_bin_xcvr: digit count exceeds binary width");
   end

   logic launch, last, first, is_store, rd, wr;
   logic [7:0] sign_byte, pair_byte;

   bcd_step_seq #(.NBYTE(NBYTE), .AW(AW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .store_mode(store_mode),
      .launch(launch), .busy(busy), .done(done), .last(last), .first(first),
      .is_store(is_store), .rd(rd), .wr(wr), .addr(byte_addr)
   );

   bcd_load_acc #(.BW(BW)) u_load (
      .clk(clk), .rst_n(rst_n), .clr(launch),
      .en_pair(rd && !last), .en_sign(rd && last),
      .byte_in(ld_byte), .result(bin_out), .bad(bad_digit)
   );

   bcd_store_gen #(.BW(BW), .NPAIR(NPAIR)) u_store (
      .clk(clk), .rst_n(rst_n), .launch(launch), .is_store(store_mode),
      .value(bin_in), .shift(wr && !first),
      .sign_byte(sign_byte), .pair_byte(pair_byte), .ovf(overflow)
   );

   assign byte_rd = rd;
   assign byte_wr = wr;
   assign st_byte = !wr ? 8'h00 : (first ? sign_byte : pair_byte);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!byte_rd && !byte_wr && st_byte == 8'h00));
   a_r11_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable({bad_digit, overflow}));
   a_r7_store_sign_byte: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_wr && byte_addr == AW'(NBYTE - 1)) |-> (st_byte[6:0] == 7'd0));

endmodule

// File: tb/tb_bcd_bin_xcvr.sv
module tb_bcd_bin_xcvr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        store_mode = 1'b0;
   logic [63:0] bin_in = '0;
   logic [7:0]  ld_byte;
   logic [3:0]  byte_addr;
   logic        byte_rd, byte_wr, busy, done, bad_digit, overflow;
   logic [7:0]  st_byte;
   logic [63:0] bin_out;

   logic [7:0]  mem [16];
   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   assign ld_byte = mem[byte_addr];

   bcd_bin_xcvr dut (
      .clk(clk), .rst_n(rst_n), .start(start), .store_mode(store_mode),
      .bin_in(bin_in), .ld_byte(ld_byte), .byte_addr(byte_addr),
      .byte_rd(byte_rd), .byte_wr(byte_wr), .st_byte(st_byte),
      .busy(busy), .done(done), .bin_out(bin_out),
      .bad_digit(bad_digit), .overflow(overflow)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic set_mem(input logic [71:0] pairs, input logic [7:0] sgn);
      for (int i = 0; i < 9; i++) mem[i] = pairs[8*i +: 8];
      mem[9] = sgn;
      for (int i = 10; i < 16; i++) mem[i] = 8'h00;
   endtask

   // model of a load: expected value and flag from mem contents
   task automatic run_load(input bit glitch);
      logic [63:0] acc = '0;
      bit          bad = 1'b0;
      int          hi, lo;
      for (int i = 8; i >= 0; i--) begin
         hi = int'(mem[i][7:4]);
         lo = int'(mem[i][3:0]);
         if (hi > 9 || lo > 9) bad = 1'b1;
         acc = acc * 64'd100 + 64'(hi * 10 + lo);
      end
      if (mem[9][7]) acc = -acc;
      @(negedge clk);
      start = 1'b1; store_mode = 1'b0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         start = (glitch && k == 4);
         chk("R2 busy during load", 64'(busy), 64'd1);
         chk("R2 no done while busy", 64'(done), 64'd0);
         chk("R3 load read strobe", 64'({byte_rd, byte_wr}), 64'b10);
         chk("R3 load address", 64'(byte_addr), (k < 9) ? 64'(8 - k) : 64'd9);
      end
      @(negedge clk);
      start = 1'b0;
      chk("R2 done pulse", 64'({busy, done}), 64'b01);
      chk("R4 R5 load value", bin_out, acc);
      chk("R6 bad digit flag", 64'(bad_digit), 64'(bad));
      chk("R11 overflow cleared by load", 64'(overflow), 64'd0);
      @(negedge clk);
      chk("R2 done falls", 64'({busy, done}), 64'b00);
      repeat (2) @(negedge clk);
      chk("R11 value held", bin_out, acc);
   endtask

   task automatic run_store(input logic [63:0] v, input bit glitch);
      logic [63:0] mag;
      logic [63:0] keep;
      logic [63:0] r;
      keep = bin_out;
      mag  = v[63] ? (~v + 64'd1) : v;
      @(negedge clk);
      start = 1'b1; store_mode = 1'b1; bin_in = v;
      @(negedge clk);
      start = 1'b0; bin_in = ~v;
      chk("R7 sign byte strobe", 64'({byte_rd, byte_wr}), 64'b01);
      chk("R7 sign byte address", 64'(byte_addr), 64'd9);
      chk("R7 sign byte value", 64'(st_byte), v[63] ? 64'h80 : 64'h00);
      for (int k = 1; k < 10; k++) begin
         @(negedge clk);
         start = (glitch && k == 5);
         r = mag % 64'd100;
         chk("R2 busy during store", 64'(busy), 64'd1);
         chk("R8 store address", 64'(byte_addr), 64'(k - 1));
         chk("R8 R9 store byte", 64'(st_byte), ((r / 64'd10) << 4) | (r % 64'd10));
         mag = mag / 64'd100;
      end
      @(negedge clk);
      start = 1'b0;
      chk("R2 store done pulse", 64'({busy, done}), 64'b01);
      chk("R10 overflow flag", 64'(overflow),
          64'((v[63] ? (~v + 64'd1) : v) >= 64'd1000000000000000000));
      chk("R11 bad digit cleared by store", 64'(bad_digit), 64'd0);
      chk("R11 store leaves value", bin_out, keep);
      @(negedge clk);
      chk("R2 store done falls", 64'(done), 64'd0);
   endtask

   initial begin
      set_mem(72'h0, 8'h00);
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", 64'({busy, done, byte_rd, byte_wr, bad_digit, overflow}), 64'd0);
      chk("R1 reset value", bin_out, 64'd0);
      chk("R1 reset store byte", 64'(st_byte), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      set_mem(72'h12_3456_7890_1234_5678, 8'h00);  run_load(1'b0); // R4
      set_mem(72'h12_3456_7890_1234_5678, 8'h80);  run_load(1'b1); // R5, R2 glitch
      set_mem(72'h99_9999_9999_9999_9999, 8'hFF);  run_load(1'b0); // R5 other bits
      set_mem(72'h00_0000_0000_0000_4321, 8'h7F);  run_load(1'b0); // R5 bit 7 clear
      set_mem(72'h00_0000_0000_00A5_0F01, 8'h00);  run_load(1'b0); // R6
      set_mem(72'h00_0000_0000_0000_0000, 8'h80);  run_load(1'b0); // R5 negative zero

      run_store(64'd0, 1'b0);                                       // R9
      run_store(64'd1234, 1'b1);                                    // R8 R9, R2 glitch
      run_store(-64'sd999999999999999999, 1'b0);                   // R7 R8
      run_store(64'd999999999999999999, 1'b0);
      run_store(64'd1000000000000000000, 1'b0);                     // R10 threshold
      run_store(64'h8000_0000_0000_0000, 1'b0);                     // R10 most negative
      run_store(-64'sd7, 1'b0);                                     // R7 negative small

      set_mem(72'h00_0000_0000_0000_0042, 8'h00);  run_load(1'b0); // R11 flags cleared

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule